// File: doc/BRIEF.md
# Timer Count Source Prescaler Selector

This block decides when a timer counter advances. It runs on the timer's operating clock and issues a one-cycle count strobe. The strobe comes from one of two places. The first is a free-running prescaler that divides the operating clock by 1, 2, 4, 8 or 32. The second is an external clock pin, which is synchronized into the operating clock domain and edge-detected on a selectable edge.

A 3-bit source code chooses the ratio or the external path. A separate enable bit lets the pin act as a count source; while that bit is clear, the pin is ordinary I/O and gives no counts. The external clock's high and low phases must each last at least three operating clock cycles. The block watches the synchronized pin while the external source is active, and raises a sticky flag when a phase is shorter than that. Edges that reach the synchronizer output are still counted. The consuming counter and the clock tree ahead of the block are outside it.

Top module: `tcs_count_source`

## Requirements
- R1: While reset is high, and in the first cycle after it, count_strobe_o and pw_violation_o are 0. Reset clears the prescaler and the synchronizer.
- R2: Source code 3'b000 gives a strobe in every cycle.
- R3: Source codes 3'b001, 3'b010 and 3'b011 give one strobe every 2, 4 and 8 cycles, evenly spaced.
- R4: Source code 3'b100 gives one strobe every 32 cycles. There is no divide-by-16 code.
- R5: The prescaler is a 5-bit counter. It starts at 0 after reset and steps by one every cycle. A change of source code takes effect at the next clock edge and does not restart the counter. The strobe registered at clock edge e (the first edge after reset is e=1) is high when (e-1) mod ratio == 0.
- R6: Source codes 3'b110 and 3'b111 give no strobes.
- R7: Source code 3'b101 takes counts from the pin only when ext_en_i is 1. With ext_en_i at 0, the pin gives no strobes.
- R8: The edge select chooses which pin edges count: 2'b00 counts rising edges, 2'b01 falling edges, 2'b10 both edges, and 2'b11 rising edges.
- R9: Suppose a qualifying pin change is set up before clock edge k. Then count_strobe_o is high for exactly one cycle, following edge k+2, and the edge gives exactly one strobe.
- R10: While the external source is active, a synchronized high or low phase shorter than 3 cycles sets pw_violation_o. Only reset clears it. A phase of exactly 3 cycles does not set it, and edges of short phases are still counted.
- R11: pw_violation_o is not set by pin activity while the external source is inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Timer operating clock |
| rst_i | input | 1 | Synchronous reset, active high |
| src_sel_i | input | 3 | Count source code |
| ext_en_i | input | 1 | Lets the pin act as count source for code 3'b101 |
| edge_sel_i | input | 2 | Active edge choice for the pin |
| ext_clk_i | input | 1 | Raw external clock pin |
| count_strobe_o | output | 1 | One-cycle count enable for the timer counter |
| pw_violation_o | output | 1 | Sticky flag for a short external pulse phase |

## Verification
The bench switches between division ratios without a reset and predicts every cycle from the free-running count. A design that restarted the prescaler on a code change, or that added a divide-by-16 step, would put strobes in the wrong cycles. The external tests count strobes per pulse train for each edge code, with 2'b11 checked apart from 2'b00, and measure the exact two-stage latency. A double-counted edge or an extra synchronizer stage shows up in those counts and in that latency. A phase of exactly three cycles must leave the flag clear and a two-cycle phase must set it. The flag must survive later clean pulses and stay clear for pin activity while the enable bit is low. An off-by-one width compare, or a flag that is not sticky, fails these checks.

// File: rtl/tcs_pkg.sv
package tcs_pkg;

  typedef enum logic [2:0] {
    SRC_DIV1  = 3'b000,
    SRC_DIV2  = 3'b001,
    SRC_DIV4  = 3'b010,
    SRC_DIV8  = 3'b011,
    SRC_DIV32 = 3'b100,
    SRC_PIN   = 3'b101,
    SRC_OFF_A = 3'b110,
    SRC_OFF_B = 3'b111
  } src_code_e;

  typedef enum logic [1:0] {
    EDGE_RISE = 2'b00,
    EDGE_FALL = 2'b01,
    EDGE_BOTH = 2'b10,
    EDGE_RISE_ALT = 2'b11
  } edge_code_e;

  // True for codes served by the prescaler
  function automatic logic code_is_internal(input logic [2:0] code);
    return (code <= SRC_DIV32);
  endfunction

  // log2 of the division ratio for an internal code
  function automatic int unsigned div_shift(input logic [2:0] code);
    case (code)
      SRC_DIV1:  return 0;
      SRC_DIV2:  return 1;
      SRC_DIV4:  return 2;
      SRC_DIV8:  return 3;
      SRC_DIV32: return 5;
      default:   return 0;
    endcase
  endfunction

  // Does a detected transition qualify under the chosen edge code
  function automatic logic edge_qualifies(input logic [1:0] mode,
                                          input logic rise,
                                          input logic fall);
    case (mode)
      EDGE_FALL: return fall;
      EDGE_BOTH: return rise | fall;
      default:   return rise;
    endcase
  endfunction

endpackage

// File: rtl/tcs_prescaler.sv
module tcs_prescaler #(
  parameter int PRE_W = 5
) (
  input  logic           clk_i,
  input  logic           rst_i,
  output logic [PRE_W:0] wrap_o
);

  logic [PRE_W-1:0] cnt_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) cnt_q <= '0;
    else       cnt_q <= cnt_q + 1'b1;
  end

  // wrap_o[i] flags that the low i bits of the count are all zero
  for (genvar i = 0; i <= PRE_W; i++) begin : g_wrap
    if (i == 0) begin : g_always
      assign wrap_o[i] = 1'b1;
    end else begin : g_low
      assign wrap_o[i] = ~|cnt_q[i-1:0];
    end
  end

  // R5: free-running, one step per clock, never restarted except by reset
  assert_cnt_step_R5: assert property (@(posedge clk_i) disable iff (rst_i)
    !$past(rst_i) |-> cnt_q == PRE_W'($past(cnt_q) + 1'b1));

endmodule

// File: rtl/tcs_ext_edge.sv
module tcs_ext_edge
  import tcs_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int MIN_PW      = 3
) (
  input  logic       clk_i,
  input  logic       rst_i,
  input  logic       pin_i,
  input  logic       active_i,
  input  logic [1:0] edge_sel_i,
  output logic       hit_o,
  output logic       viol_o
);

  localparam int RUN_W = $clog2(MIN_PW + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic [RUN_W-1:0]       run_q;
  logic                   viol_q;

  logic level_w, rise_w, fall_w, change_w, short_w;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign level_w  = sync_q[SYNC_STAGES-1];
  assign rise_w   = level_w & ~prev_q;
  assign fall_w   = ~level_w & prev_q;
  assign change_w = rise_w | fall_w;
  assign short_w  = change_w && (run_q < RUN_W'(MIN_PW));
  assign hit_o    = edge_qualifies(edge_sel_i, rise_w, fall_w);

  // Phase length tracker, saturating at MIN_PW; starts saturated after reset
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      run_q  <= RUN_W'(MIN_PW);
      viol_q <= 1'b0;
    end else begin
      if (change_w)                    run_q <= RUN_W'(1);
      else if (run_q < RUN_W'(MIN_PW)) run_q <= run_q + 1'b1;
      if (short_w && active_i)         viol_q <= 1'b1;
    end
  end

  assign viol_o = viol_q;

  // R10: the violation flag is sticky until reset
  assert_viol_sticky_R10: assert property (@(posedge clk_i) disable iff (rst_i)
    (!$past(rst_i) && $past(viol_o)) |-> viol_o);

  // R11: the flag only rises after a cycle in which the external source was active
  assert_viol_active_R11: assert property (@(posedge clk_i) disable iff (rst_i)
    (!$past(rst_i) && $rose(viol_o)) |-> $past(active_i));

endmodule

// File: rtl/tcs_count_source.sv
module tcs_count_source
  import tcs_pkg::*;
#(
  parameter int PRE_W       = 5,
  parameter int SYNC_STAGES = 2,
  parameter int MIN_PW      = 3
) (
  input  logic       clk_i,
  input  logic       rst_i,
  input  logic [2:0] src_sel_i,
  input  logic       ext_en_i,
  input  logic [1:0] edge_sel_i,
  input  logic       ext_clk_i,
  output logic       count_strobe_o,
  output logic       pw_violation_o
);

  logic [PRE_W:0] wrap_w;
  logic           ext_active_w;
  logic           int_active_w;
  logic           ext_hit_w;
  logic           int_hit_w;
  logic           strobe_d;
  logic           strobe_q;

  tcs_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .wrap_o (wrap_w)
  );

  assign ext_active_w = (src_sel_i == SRC_PIN) && ext_en_i;
  assign int_active_w = code_is_internal(src_sel_i);

  tcs_ext_edge #(.SYNC_STAGES(SYNC_STAGES), .MIN_PW(MIN_PW)) u_ext (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .pin_i      (ext_clk_i),
    .active_i   (ext_active_w),
    .edge_sel_i (edge_sel_i),
    .hit_o      (ext_hit_w),
    .viol_o     (pw_violation_o)
  );

  always_comb begin
    int_hit_w = wrap_w[div_shift(src_sel_i)];
    if (int_active_w)      strobe_d = int_hit_w;
    else if (ext_active_w) strobe_d = ext_hit_w;
    else                   strobe_d = 1'b0;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) strobe_q <= 1'b0;
    else       strobe_q <= strobe_d;
  end

  assign count_strobe_o = strobe_q;

  // R2: divide-by-one counts every cycle
  assert_div1_every_R2: assert property (@(posedge clk_i) disable iff (rst_i)
    (src_sel_i == SRC_DIV1) |=> count_strobe_o);

  // R6: unused codes never count
  assert_off_codes_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    (src_sel_i == SRC_OFF_A || src_sel_i == SRC_OFF_B) |=> !count_strobe_o);

  // R7: pin source without its enable gives no counts
  assert_pin_gated_R7: assert property (@(posedge clk_i) disable iff (rst_i)
    (src_sel_i == SRC_PIN && !ext_en_i) |=> !count_strobe_o);

  // R1: first cycle after reset carries no strobe
  assert_reset_quiet_R1: assert property (@(posedge clk_i)
    rst_i |=> !count_strobe_o);

endmodule

// File: tb/tcs_count_source_tb.sv
`timescale 1ns/1ps
module tcs_count_source_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] sel = 3'b000;
  logic       en  = 1'b0;
  logic [1:0] edg = 2'b00;
  logic       pin = 1'b0;
  logic       strobe, viol;

  int checks = 0;
  int fails  = 0;
  int ecount = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  tcs_count_source u_dut (
    .clk_i(clk), .rst_i(rst), .src_sel_i(sel), .ext_en_i(en),
    .edge_sel_i(edg), .ext_clk_i(pin),
    .count_strobe_o(strobe), .pw_violation_o(viol)
  );

  always @(posedge clk) begin
    if (rst) ecount <= 0;
    else     ecount <= ecount + 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int ratio_of(input logic [2:0] s);
    case (s)
      3'b000: return 1;
      3'b001: return 2;
      3'b010: return 4;
      3'b011: return 8;
      3'b100: return 32;
      default: return 0;
    endcase
  endfunction

  // Internal table: code, enable, expected strobes in 64 cycles
  localparam int NROW = 9;
  localparam logic [2:0] T_SEL [NROW] = '{3'b000, 3'b001, 3'b010, 3'b011, 3'b100,
                                          3'b110, 3'b111, 3'b101, 3'b010};
  localparam logic       T_EN  [NROW] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0,
                                          1'b0, 1'b0, 1'b0, 1'b1};
  localparam int         T_EXP [NROW] = '{64, 32, 16, 8, 2, 0, 0, 0, 16};
  localparam string      T_REQ [NROW] = '{"R2", "R3", "R3", "R3", "R4",
                                          "R6", "R6", "R7", "R5"};

  task automatic pulse_train(input int n, input int hi, input int lo,
                             output int ticks, output int doubles);
    bit prev = 1'b0;
    ticks = 0; doubles = 0;
    for (int p = 0; p < n; p++) begin
      pin = 1'b1;
      for (int c = 0; c < hi; c++) begin
        @(negedge clk);
        if (strobe) begin ticks++; if (prev) doubles++; end
        prev = strobe;
      end
      pin = 1'b0;
      for (int c = 0; c < lo; c++) begin
        @(negedge clk);
        if (strobe) begin ticks++; if (prev) doubles++; end
        prev = strobe;
      end
    end
    for (int c = 0; c < 6; c++) begin
      @(negedge clk);
      if (strobe) begin ticks++; if (prev) doubles++; end
      prev = strobe;
    end
  endtask

  initial begin
    int ticks, dbl, miss;
    bit exp_s;

    repeat (3) @(negedge clk);
    chk(strobe == 1'b0, "R1 strobe in reset", strobe, 0);
    chk(viol == 1'b0, "R1 flag in reset", viol, 0);
    rst = 1'b0;

    // Table walk: no reset between rows, so the phase model checks R5
    for (int r = 0; r < NROW; r++) begin
      sel = T_SEL[r];
      en  = T_EN[r];
      ticks = 0; miss = 0;
      for (int c = 0; c < 64; c++) begin
        @(negedge clk);
        exp_s = (ratio_of(sel) != 0) && (((ecount - 1) % ratio_of(sel)) == 0);
        if (strobe) ticks++;
        if (strobe != exp_s) miss++;
      end
      chk(ticks == T_EXP[r], T_REQ[r], ticks, T_EXP[r]);
      chk(miss == 0, "R5 phase", miss, 0);
    end

    // External path, rising edges, latency
    sel = 3'b101; en = 1'b1; edg = 2'b00; pin = 1'b0;
    repeat (6) @(negedge clk);
    pin = 1'b1;
    @(negedge clk); chk(strobe == 1'b0, "R9 edge+1", strobe, 0);
    @(negedge clk); chk(strobe == 1'b0, "R9 edge+2", strobe, 0);
    @(negedge clk); chk(strobe == 1'b1, "R9 edge+3", strobe, 1);
    @(negedge clk); chk(strobe == 1'b0, "R9 one cycle", strobe, 0);
    repeat (4) @(negedge clk);
    pin = 1'b0;
    repeat (6) @(negedge clk);

    // Edge codes
    edg = 2'b00; pulse_train(5, 4, 4, ticks, dbl);
    chk(ticks == 5, "R8 rising", ticks, 5);
    chk(dbl == 0, "R9 single strobe", dbl, 0);
    edg = 2'b01; pulse_train(5, 4, 4, ticks, dbl);
    chk(ticks == 5, "R8 falling", ticks, 5);
    edg = 2'b10; pulse_train(5, 4, 4, ticks, dbl);
    chk(ticks == 10, "R8 both", ticks, 10);
    chk(dbl == 0, "R9 both single", dbl, 0);
    edg = 2'b11; pulse_train(5, 4, 4, ticks, dbl);
    chk(ticks == 5, "R8 code 11", ticks, 5);

    // Exactly three-cycle phases: no violation
    edg = 2'b00; pulse_train(5, 3, 3, ticks, dbl);
    chk(ticks == 5, "R10 width 3 counts", ticks, 5);
    chk(viol == 1'b0, "R10 width 3 flag", viol, 0);

    // Pin disabled: no counts, no flag from short pulses
    en = 1'b0; pulse_train(5, 1, 1, ticks, dbl);
    chk(ticks == 0, "R7 pin disabled", ticks, 0);
    chk(viol == 1'b0, "R11 inactive flag", viol, 0);
    pulse_train(3, 4, 4, ticks, dbl);

    // Short high phase while active
    en = 1'b1; pulse_train(5, 2, 4, ticks, dbl);
    chk(viol == 1'b1, "R10 short sets flag", viol, 1);
    chk(ticks == 5, "R10 short still counts", ticks, 5);
    pulse_train(3, 5, 5, ticks, dbl);
    chk(viol == 1'b1, "R10 sticky", viol, 1);

    // Reset clears flag and strobe
    sel = 3'b000;
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    chk(viol == 1'b0, "R1 flag cleared", viol, 0);
    chk(strobe == 1'b0, "R1 strobe cleared", strobe, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(strobe == 1'b1, "R2 first edge after reset", strobe, 1);

    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule